// File: doc/BRIEF.md
# Power-Good Qualification Timer

This block drives the power-good status of a supply supervisor. Three synchronised level flags feed it. The first says that the external power-good input sits above its upper threshold. The other two say that the 3.3 V rail and the 5 V rail are each above their under-voltage levels. The protection controller supplies two more inputs: a latched-fault status and a supply-off status. Time is measured in pulses of a one-cycle tick that the chip provides once per microsecond.

The output is asymmetric. It rises only after every monitored flag has held good for a long qualification window, 300 ms by default. It falls after a short debounce window, 150 µs by default, once any flag goes bad and stays bad. A latched fault or a supply-off command pulls the output low on the very next clock edge, whatever the flags show. After any drop, the output stays low until a complete new qualification window has elapsed.

Top module: `pwr_good_gen`

## Requirements
- R1: `pg_o` is 0 while `rst_ni` is low and stays 0 after reset until a full qualification completes.
- R2: With all three flags at 1 and both `fault_latched_i` and `supply_off_i` at 0, `pg_o` becomes 1 on the clock edge that samples the RISE_TICKS-th `tick_i` pulse of the good run, and not before.
- R3: If any flag is 0 in any cycle of a qualification run, the tick count restarts from zero, so a further RISE_TICKS ticks of all-good are needed.
- R4: `pgi_hi_i` at 0 means the power-good input is at or below its upper threshold, including the band between its two thresholds. It holds `pg_o` at 0 regardless of the two rail flags.
- R5: While `pg_o` is 1, a flag that stays 0 through FALL_TICKS consecutive tick pulses clears `pg_o` on the edge that samples the FALL_TICKS-th pulse.
- R6: A bad interval shorter than FALL_TICKS ticks leaves `pg_o` at 1. Its count is not kept: the next bad interval starts again from zero.
- R7: `fault_latched_i` at 1 clears `pg_o` on the next clock edge and holds it at 0 for as long as the input stays 1, whatever the flags are.
- R8: `supply_off_i` at 1 clears `pg_o` on the next clock edge and holds it at 0 for as long as the input stays 1, whatever the flags are.
- R9: After `pg_o` falls for any reason, it returns to 1 only after a full new run of RISE_TICKS good ticks.
- R10: Apart from the clears of R7 and R8, `pg_o` changes only on an edge where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle time base pulse, nominally every 1 µs |
| pgi_hi_i | input | 1 | Power-good input above its upper threshold |
| rail33_ok_i | input | 1 | 3.3 V rail above its under-voltage level |
| rail5_ok_i | input | 1 | 5 V rail above its under-voltage level |
| fault_latched_i | input | 1 | Protection latch is set |
| supply_off_i | input | 1 | Main supply is commanded off |
| pg_o | output | 1 | Power-good status |

## Verification
The bench uses RISE_TICKS=6 and FALL_TICKS=3. It drives `tick_i` for one cycle in every three. Each rise or fall is therefore due on the edge that samples the N-th tick pulse, and the bench counts tick pulses rather than cycles. Checks run on the falling edge after the last tick of a sequence. For every tick count one below and one above each window, the expected value is computed from that count. The clears caused by a fault or by supply-off are due one edge after the input changes, and they are checked on the next falling edge.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef struct packed {
    logic pgi_hi;
    logic rail33;
    logic rail5;
  } pg_flags_t;

  typedef enum logic {PG_LOW = 1'b0, PG_HIGH = 1'b1} pg_state_e;

  function automatic logic flags_all_good(input pg_flags_t f);
    return f.pgi_hi & f.rail33 & f.rail5;
  endfunction
endpackage

// File: rtl/pg_tick_timer.sv
module pg_tick_timer #(
  parameter int unsigned LIMIT = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign expire_o = run_i & tick_i & (cnt_q == LAST);

  // any cycle without run clears the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (expire_o)  cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwr_good_gen.sv
module pwr_good_gen #(
  parameter int unsigned RISE_TICKS = 300000,
  parameter int unsigned FALL_TICKS = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pgi_hi_i,
  input  logic rail33_ok_i,
  input  logic rail5_ok_i,
  input  logic fault_latched_i,
  input  logic supply_off_i,
  output logic pg_o
);
  import pg_pkg::*;

  pg_flags_t flags;
  pg_state_e state_q, state_d;
  logic all_good, force_low, rise_run, fall_run, rise_exp, fall_exp;

  assign flags     = '{pgi_hi: pgi_hi_i, rail33: rail33_ok_i, rail5: rail5_ok_i};
  assign all_good  = flags_all_good(flags);
  assign force_low = fault_latched_i | supply_off_i;
  assign rise_run  = (state_q == PG_LOW)  & all_good  & ~force_low;
  assign fall_run  = (state_q == PG_HIGH) & ~all_good & ~force_low;

  pg_tick_timer #(.LIMIT(RISE_TICKS)) u_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(rise_run), .tick_i(tick_i), .expire_o(rise_exp)
  );

  pg_tick_timer #(.LIMIT(FALL_TICKS)) u_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(fall_run), .tick_i(tick_i), .expire_o(fall_exp)
  );

  always_comb begin
    state_d = state_q;
    if (force_low)     state_d = PG_LOW;
    else if (rise_exp) state_d = PG_HIGH;
    else if (fall_exp) state_d = PG_LOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PG_LOW;
    else         state_q <= state_d;
  end

  assign pg_o = (state_q == PG_HIGH);
endmodule

// File: rtl/pwr_good_gen_chk.sv
module pwr_good_gen_chk #(
  parameter int unsigned RISE_TICKS = 300000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic pgi_hi_i,
  input logic rail33_ok_i,
  input logic rail5_ok_i,
  input logic fault_latched_i,
  input logic supply_off_i,
  input logic pg_o
);
  localparam int unsigned W = $clog2(RISE_TICKS + 1);
  localparam logic [W-1:0] LAST = W'(RISE_TICKS - 1);

  logic good, frc, qual;
  logic [W-1:0] good_ticks;

  assign good = pgi_hi_i & rail33_ok_i & rail5_ok_i;
  assign frc  = fault_latched_i | supply_off_i;
  assign qual = good & ~frc & ~pg_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          good_ticks <= '0;
    else if (!qual)                       good_ticks <= '0;
    else if (tick_i && good_ticks != '1)  good_ticks <= good_ticks + 1'b1;
  end

  AST_RESET_LOW: assert property (@(posedge clk_i) !rst_ni |=> (!rst_ni |-> !pg_o)); // R1
  AST_RISE_FULL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_o) |-> ($past(good_ticks) == LAST)); // R2
  AST_BAD_BLOCKS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pg_o && !good) |=> !pg_o); // R4
  AST_FAULT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_latched_i |=> !pg_o); // R7
  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_off_i |=> !pg_o); // R8
  AST_GOOD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_o && good && !frc) |=> pg_o); // R6
  AST_NO_TICK_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pg_o && !tick_i) |=> !pg_o); // R10
  AST_NO_TICK_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_o && !tick_i && !frc) |=> pg_o); // R10
endmodule

bind pwr_good_gen pwr_good_gen_chk #(.RISE_TICKS(RISE_TICKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pgi_hi_i(pgi_hi_i),
  .rail33_ok_i(rail33_ok_i), .rail5_ok_i(rail5_ok_i),
  .fault_latched_i(fault_latched_i), .supply_off_i(supply_off_i), .pg_o(pg_o)
);

// File: tb/pwr_good_gen_test.sv
`timescale 1ns/1ps
module pwr_good_gen_test;
  localparam int unsigned RISE = 6;
  localparam int unsigned FALL = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic pgi_hi_i = 1'b0, rail33_ok_i = 1'b0, rail5_ok_i = 1'b0;
  logic fault_latched_i = 1'b0, supply_off_i = 1'b0;
  logic pg_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_good_gen #(.RISE_TICKS(RISE), .FALL_TICKS(FALL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .pgi_hi_i(pgi_hi_i),
    .rail33_ok_i(rail33_ok_i), .rail5_ok_i(rail5_ok_i),
    .fault_latched_i(fault_latched_i), .supply_off_i(supply_off_i), .pg_o(pg_o)
  );

  task automatic chk(input logic exp, input string req);
    checks++;
    if (pg_o !== exp) begin
      fails++;
      $display("FAIL %s: pg_o=%0b expected %0b", req, pg_o, exp);
    end
  endtask

  // each pulse: tick high for one cycle, low for two
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic flags(input logic p, input logic a, input logic b);
    @(negedge clk);
    pgi_hi_i = p; rail33_ok_i = a; rail5_ok_i = b;
  endtask

  // one cycle of supply-off clears state, then inputs idle-good
  task automatic clear_state();
    @(negedge clk) supply_off_i = 1'b1;
    @(negedge clk) supply_off_i = 1'b0; fault_latched_i = 1'b0;
  endtask

  task automatic bring_up();
    clear_state();
    flags(1, 1, 1);
    ticks(RISE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: pg_o=%0b expected finish", pg_o);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1'b0, "R1 after reset");
    flags(1, 1, 1);
    ticks(RISE - 1);
    chk(1'b0, "R1 no early rise");

    // exhaustive over {pgi, r33, r5, fault, off}
    for (int v = 0; v < 32; v++) begin
      clear_state();
      flags(v[4], v[3], v[2]);
      fault_latched_i = v[1]; supply_off_i = v[0];
      ticks(RISE + 1);
      chk((v == 28) ? 1'b1 : 1'b0,
          v[1] ? "R7 fault sweep" : v[0] ? "R8 off sweep" : v[4] ? "R2 flag sweep" : "R4 pgi sweep");
    end
    fault_latched_i = 1'b0; supply_off_i = 1'b0;

    // rise window boundary
    for (int k = 0; k <= RISE + 1; k++) begin
      clear_state();
      flags(1, 1, 1);
      ticks(k);
      chk((k >= RISE) ? 1'b1 : 1'b0, "R2 window");
    end

    // restart on a one-cycle glitch
    clear_state();
    flags(1, 1, 1);
    ticks(RISE - 1);
    flags(1, 0, 1);
    flags(1, 1, 1);
    ticks(RISE - 1);
    chk(1'b0, "R3 restarted");
    ticks(1);
    chk(1'b1, "R3 full run");

    // fall window boundary and requalify
    for (int k = 0; k <= FALL + 1; k++) begin
      bring_up();
      chk(1'b1, "R5 up");
      flags(k[0], 1, 1 ^ k[0]);
      ticks(k);
      chk((k < FALL) ? 1'b1 : 1'b0, "R5 fall window");
      flags(1, 1, 1);
      @(negedge clk);
      chk((k < FALL) ? 1'b1 : 1'b0, "R6 short pulse");
      if (k >= FALL) begin
        ticks(RISE - 1);
        chk(1'b0, "R9 requalify");
        ticks(1);
        chk(1'b1, "R9 back up");
      end
    end

    // bad count does not accumulate
    bring_up();
    flags(1, 1, 0);
    ticks(FALL - 1);
    flags(1, 1, 1);
    flags(1, 1, 0);
    ticks(FALL - 1);
    chk(1'b1, "R6 no accumulation");
    ticks(1);
    chk(1'b0, "R5 consecutive");
    flags(1, 1, 1);

    // fault override
    bring_up();
    @(negedge clk) fault_latched_i = 1'b1;
    @(negedge clk);
    chk(1'b0, "R7 next edge");
    ticks(RISE + 2);
    chk(1'b0, "R7 held");
    fault_latched_i = 1'b0;
    ticks(RISE - 1);
    chk(1'b0, "R9 after fault");
    ticks(1);
    chk(1'b1, "R9 up after fault");

    // supply-off override
    @(negedge clk) supply_off_i = 1'b1;
    @(negedge clk);
    chk(1'b0, "R8 next edge");
    ticks(RISE + 2);
    chk(1'b0, "R8 held");
    supply_off_i = 1'b0;
    ticks(RISE);
    chk(1'b1, "R8 release");

    // no change without a tick
    flags(0, 1, 1);
    repeat (20) @(negedge clk);
    chk(1'b1, "R10 hold without tick");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule